// File: doc/BRIEF.md
# Zero-Crossing Stereo Mute Controller

This block sits in a stereo sample path and decides, per channel, whether the samples pass or are replaced by exact zeros. The mute request comes from one bit of a control word. A second bit of that word picks how the switch moves. In direct mode both channels follow the request on the next clock. In crossing mode each channel waits for its own next zero crossing, so that muting or unmuting does not click. Each write of the control word starts a timeout. When the timeout runs out with no crossing seen, the switch follows the request anyway.

Two further mute sources act at once and bypass the crossing logic. The first is an active-low force pin, which mutes both channels while it is held low. After the pin is released the mute stays on for a short, fixed delay and then clears. The pin state is not stored. The second is a per-channel attenuation code from the volume stage, which mutes its channel when the code is below 8.

Samples enter and leave through a one-stage valid/ready register. A sample is taken on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or the sink asserts `out_ready` in the same cycle. While `out_valid` is high and `out_ready` is low, the output data is held and no new sample is taken. The source should keep its sample and `in_valid` steady until the sample is taken.

Top module: `zc_mute_ctrl`

## Requirements
- R1: With `zc_mode` low, each channel's switch state equals `mute_req` one clock edge later, on both channels together.
- R2: With `zc_mode` high, a channel's switch state changes only on an edge that takes a sample counting as a zero crossing on that channel, or while the timeout has expired.
- R3: The left and right crossing detectors work independently, so one channel may switch while the other keeps its old state.
- R4: The timeout counter restarts on every edge where `cfg_write` is high. If no crossing occurs, a pending change takes effect on the edge that comes TIMEOUT_CYC+1 edges after the write edge, and not before it.
- R5: One edge after `force_mute_n` is sampled low, both mute flags are high, and every sample taken from then on is output as zero.
- R6: The force-pin mute is not latched. It clears on the RELEASE_CYC-th edge at which the pin is sampled high, and the flags then show the switch states set by the control bits.
- R7: An attenuation code below 8 (upper three bits 000) mutes its channel at once, in either mode, and the flag rises in the same cycle.
- R8: During reset and after it, both switch states are muted and `out_valid` is low.
- R9: A sample taken while its channel is muted comes out as 0. Otherwise it comes out unchanged on the next edge. The mute decision includes a switch change made on that same edge.
- R10: A taken sample counts as a zero crossing when its sign bit differs from that of the previous sample taken on that channel, or when its magnitude is at most `win_mag`. The previous sign resets to non-negative.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output data stays stable.
- R12: Each mute flag is the OR of the channel's registered switch state, its attenuation mute and the force-pin hold. It shows the actual state, not the requested one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair valid |
| in_ready | output | 1 | Block can take a sample pair |
| din_l | input | DW | Left sample, two's complement |
| din_r | input | DW | Right sample, two's complement |
| out_valid | output | 1 | Output sample pair valid |
| out_ready | input | 1 | Sink takes the output pair |
| dout_l | output | DW | Gated left sample |
| dout_r | output | DW | Gated right sample |
| win_mag | input | DW | Magnitude window treated as a crossing |
| mute_req | input | 1 | Requested mute state from the control word |
| zc_mode | input | 1 | 1: switch at zero crossings, 0: switch directly |
| cfg_write | input | 1 | One-cycle pulse for each write of the control word |
| force_mute_n | input | 1 | Active-low force mute pin |
| atten_l | input | 6 | Left volume-stage attenuation code |
| atten_r | input | 6 | Right volume-stage attenuation code |
| mute_l | output | 1 | Left channel actually muted |
| mute_r | output | 1 | Right channel actually muted |

## Verification
A stuck or wrong switch state shows on the mute flag one edge after the event that should have moved it. It also shows in the first sample taken after that edge, which is zero where it should pass or passes where it should be zero. A wrong previous-sign bit or a bad window compare shows as a channel that switches one sample early or late. This is seen on the flag of only that channel. A timeout counter that is off by one, or that is not restarted, moves the fallback switch by a few edges, which a count of edges after the write exposes. A release hold that is latched or too short shows on both flags during the RELEASE_CYC edges after the pin goes high.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
  localparam int unsigned NCH  = 2;
  localparam int unsigned ATTW = 6;

  // attenuation codes below 8 (top three bits zero) mean "channel off"
  function automatic logic atten_mutes(input logic [ATTW-1:0] code);
    return code < {3'b001, {(ATTW-3){1'b0}}};
  endfunction
endpackage

// File: rtl/zcm_zc_detect.sv
module zcm_zc_detect #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] win,
  output logic          zc
);
  logic          prev_neg;
  logic [DW-1:0] mag;

  // magnitude of a two's complement value; most negative maps to 2^(DW-1)
  always_comb begin
    mag = smp[DW-1] ? (~smp + 1'b1) : smp;
    zc  = take && ((smp[DW-1] != prev_neg) || (mag <= win));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_neg <= 1'b0;
    else if (take) prev_neg <= smp[DW-1];
  end
endmodule

// File: rtl/zcm_switch.sv
module zcm_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic zc_mode,
  input  logic zc,
  input  logic expired,
  output logic sw_q,
  output logic sw_d
);
  always_comb begin
    if (!zc_mode)          sw_d = req;
    else if (zc || expired) sw_d = req;
    else                   sw_d = sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b1;
    else        sw_q <= sw_d;
  end
endmodule

// File: rtl/zcm_timer.sv
module zcm_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= LIM;
    else if (restart)    cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  // a write in flight masks a stale expiry so the new request waits
  assign expired = (cnt == LIM) && !restart;
endmodule

// File: rtl/zcm_release.sv
module zcm_release #(
  parameter int unsigned HOLD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic hold
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!pin_n)    cnt <= CW'(HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);
endmodule

// File: rtl/zc_mute_ctrl.sv
module zc_mute_ctrl
  import zcm_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned TIMEOUT_CYC = 4_800_000,
  parameter int unsigned RELEASE_CYC = 24_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   din_l,
  input  logic [DW-1:0]   din_r,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   dout_l,
  output logic [DW-1:0]   dout_r,
  input  logic [DW-1:0]   win_mag,
  input  logic            mute_req,
  input  logic            zc_mode,
  input  logic            cfg_write,
  input  logic            force_mute_n,
  input  logic [ATTW-1:0] atten_l,
  input  logic [ATTW-1:0] atten_r,
  output logic            mute_l,
  output logic            mute_r
);
  logic take;
  logic tmr_expired;
  logic hw_hold;
  logic [NCH-1:0][DW-1:0]   smp;
  logic [NCH-1:0][DW-1:0]   gated;
  logic [NCH-1:0][ATTW-1:0] att;
  logic [NCH-1:0]           zc, sw_q, sw_d, att_m, gate;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign smp      = {din_r, din_l};
  assign att      = {atten_r, atten_l};

  zcm_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(cfg_write), .expired(tmr_expired)
  );

  zcm_release #(.HOLD(RELEASE_CYC)) u_rel (
    .clk(clk), .rst_n(rst_n), .pin_n(force_mute_n), .hold(hw_hold)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    zcm_zc_detect #(.DW(DW)) u_zc (
      .clk(clk), .rst_n(rst_n), .take(take),
      .smp(smp[ch]), .win(win_mag), .zc(zc[ch])
    );

    zcm_switch u_sw (
      .clk(clk), .rst_n(rst_n), .req(mute_req), .zc_mode(zc_mode),
      .zc(zc[ch]), .expired(tmr_expired), .sw_q(sw_q[ch]), .sw_d(sw_d[ch])
    );

    assign att_m[ch] = atten_mutes(att[ch]);
    // the sample that triggers a switch already sees the new state
    assign gate[ch]  = sw_d[ch] | att_m[ch] | hw_hold;
    assign gated[ch] = gate[ch] ? '0 : smp[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout_l    <= '0;
      dout_r    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      dout_l    <= gated[0];
      dout_r    <= gated[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign mute_l = sw_q[0] | att_m[0] | hw_hold;
  assign mute_r = sw_q[1] | att_m[1] | hw_hold;
endmodule

// File: rtl/zc_mute_ctrl_chk.sv
module zc_mute_ctrl_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] dout_l,
  input logic [DW-1:0] dout_r,
  input logic          mute_req,
  input logic          zc_mode,
  input logic          force_mute_n,
  input logic [5:0]    atten_l,
  input logic [5:0]    atten_r,
  input logic          mute_l,
  input logic          mute_r,
  input logic [1:0]    sw_q,
  input logic          expired
);
  a_r1_direct_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (!zc_mode && mute_req) |=> (mute_l && mute_r));

  a_r2_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_mode && !(in_valid && in_ready) && !expired) |=> (sw_q == $past(sw_q)));

  a_r5_pin_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    !force_mute_n |=> (mute_l && mute_r));

  a_r7_atten_left: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_l < 6'd8) |-> mute_l);

  a_r7_atten_right: assert property (@(posedge clk) disable iff (!rst_n)
    (atten_r < 6'd8) |-> mute_r);

  a_r9_zero_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && atten_l < 6'd8 && atten_r < 6'd8)
      |=> (out_valid && dout_l == '0 && dout_r == '0));

  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout_l) && $stable(dout_r)));
endmodule

bind zc_mute_ctrl zc_mute_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .dout_l(dout_l), .dout_r(dout_r),
  .mute_req(mute_req), .zc_mode(zc_mode), .force_mute_n(force_mute_n),
  .atten_l(atten_l), .atten_r(atten_r), .mute_l(mute_l), .mute_r(mute_r),
  .sw_q(sw_q), .expired(tmr_expired)
);

// File: tb/zc_mute_ctrl_test.sv
module zc_mute_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int TO  = 40;
  localparam int REL = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] din_l, din_r, dout_l, dout_r, win_mag;
  logic mute_req, zc_mode, cfg_write, force_mute_n, mute_l, mute_r;
  logic [5:0] atten_l, atten_r;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_mute_ctrl #(.DW(DW), .TIMEOUT_CYC(TO), .RELEASE_CYC(REL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .din_l(din_l), .din_r(din_r), .out_valid(out_valid), .out_ready(out_ready),
    .dout_l(dout_l), .dout_r(dout_r), .win_mag(win_mag), .mute_req(mute_req),
    .zc_mode(zc_mode), .cfg_write(cfg_write), .force_mute_n(force_mute_n),
    .atten_l(atten_l), .atten_r(atten_r), .mute_l(mute_l), .mute_r(mute_r)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit att_off(input logic [5:0] c);
    return c < 6'd8;   // R7 encoding
  endfunction

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  // reference state, derived from the requirements
  bit m_sw[2], m_pn[2], m_ov;
  int m_o[2], m_cnt, m_rel;

  always @(posedge clk) begin
    bit tk, ex, hold, z, nx;
    int s, mg;
    if (!rst_n) begin
      m_sw = '{1'b1, 1'b1}; m_pn = '{1'b0, 1'b0}; m_ov = 0;
      m_o = '{0, 0}; m_cnt = TO; m_rel = 0;
    end else begin
      tk   = in_valid && (!m_ov || out_ready);
      ex   = (m_cnt == TO) && !cfg_write;
      hold = (m_rel != 0);
      for (int ch = 0; ch < 2; ch++) begin
        s  = sx(ch == 0 ? din_l : din_r);
        mg = (s < 0) ? -s : s;
        z  = tk && (((s < 0) != m_pn[ch]) || (mg <= int'(win_mag)));
        nx = zc_mode ? ((z || ex) ? mute_req : m_sw[ch]) : mute_req;
        if (tk) begin
          m_o[ch]  = (nx || att_off(ch == 0 ? atten_l : atten_r) || hold) ? 0 : s;
          m_pn[ch] = (s < 0);
        end
        m_sw[ch] = nx;
      end
      if (tk) m_ov = 1; else if (out_ready) m_ov = 0;
      if (cfg_write) m_cnt = 0; else if (m_cnt < TO) m_cnt++;
      if (!force_mute_n) m_rel = REL; else if (m_rel > 0) m_rel--;
    end
    #3;
    if (rst_n && !done) begin
      chk(out_valid == m_ov, "R11 out_valid", out_valid, m_ov);
      chk(in_ready == (!m_ov || out_ready), "R11 in_ready", in_ready, !m_ov || out_ready);
      if (m_ov) begin
        chk(sx(dout_l) == m_o[0], "R9 dout_l", sx(dout_l), m_o[0]);
        chk(sx(dout_r) == m_o[1], "R9 dout_r", sx(dout_r), m_o[1]);
      end
      chk(mute_l == (m_sw[0] || att_off(atten_l) || m_rel != 0), "R12 mute_l",
          mute_l, m_sw[0] || att_off(atten_l) || m_rel != 0);
      chk(mute_r == (m_sw[1] || att_off(atten_r) || m_rel != 0), "R12 mute_r",
          mute_r, m_sw[1] || att_off(atten_r) || m_rel != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog all requirements act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input bit m, input bit z);
    mute_req = m; zc_mode = z; cfg_write = 1;
    @(negedge clk);
    cfg_write = 0;
  endtask

  task automatic feed(input int l, input int r);
    din_l = DW'(l); din_r = DW'(r); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    in_valid = 0; out_ready = 1; din_l = 0; din_r = 0; win_mag = 4;
    mute_req = 1; zc_mode = 0; cfg_write = 0; force_mute_n = 1;
    atten_l = 6'h3f; atten_r = 6'h3f;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mute_l == 1, "R8 reset mute_l", mute_l, 1);
    chk(mute_r == 1, "R8 reset mute_r", mute_r, 1);
    chk(out_valid == 0, "R8 reset out_valid", out_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mute_l && mute_r, "R8 muted after reset", mute_l && mute_r, 1);

    // R1 direct mode
    wr(0, 0);
    chk(!mute_l && !mute_r, "R1 direct unmute", mute_l || mute_r, 0);
    feed(1000, 1000);
    chk(sx(dout_l) == 1000, "R9 pass", sx(dout_l), 1000);
    wr(1, 0);
    chk(mute_l && mute_r, "R1 direct mute", mute_l && mute_r, 1);
    feed(1234, -77);
    chk(dout_l == 0 && dout_r == 0, "R9 zeros", sx(dout_r), 0);
    wr(0, 0);
    feed(1000, 1000);

    // R2, R3 crossing mode
    wr(1, 1);
    feed(1000, 1000);
    feed(900, 800);
    chk(!mute_l && !mute_r, "R2 deferred", mute_l || mute_r, 0);
    feed(-1000, 1000);
    chk(mute_l == 1, "R3 left switched", mute_l, 1);
    chk(mute_r == 0, "R3 right kept", mute_r, 0);
    chk(dout_l == 0, "R3 crossing sample muted", sx(dout_l), 0);
    chk(sx(dout_r) == 1000, "R3 right passes", sx(dout_r), 1000);
    feed(-1000, -1000);
    chk(mute_r == 1, "R2 right switched", mute_r, 1);

    // R10 window
    wr(0, 1);
    feed(-1000, -1000);
    chk(mute_l && mute_r, "R10 no crossing", mute_l && mute_r, 1);
    feed(-3, -5);
    chk(mute_l == 0, "R10 window crossing", mute_l, 0);
    chk(mute_r == 1, "R10 outside window", mute_r, 1);
    chk(sx(dout_l) == -3, "R10 sample passes", sx(dout_l), -3);

    // R4 timeout restart
    wr(0, 1);
    repeat (TO) @(negedge clk);
    chk(mute_r == 1, "R4 before expiry", mute_r, 1);
    @(negedge clk);
    chk(mute_r == 0, "R4 after expiry", mute_r, 0);

    // R5, R6 force pin
    force_mute_n = 0;
    @(negedge clk);
    chk(mute_l && mute_r, "R5 pin mutes", mute_l && mute_r, 1);
    feed(500, 500);
    chk(dout_l == 0 && dout_r == 0, "R5 zero samples", sx(dout_l), 0);
    force_mute_n = 1;
    repeat (REL - 1) @(negedge clk);
    chk(mute_l == 1, "R6 release delay", mute_l, 1);
    @(negedge clk);
    chk(!mute_l && !mute_r, "R6 released", mute_l || mute_r, 0);

    // R7 attenuation mute
    atten_l = 6'd7; #1;
    chk(mute_l == 1, "R7 code 7 mutes", mute_l, 1);
    chk(mute_r == 0, "R7 other channel", mute_r, 0);
    feed(300, 300);
    chk(dout_l == 0 && sx(dout_r) == 300, "R7 gated sample", sx(dout_l), 0);
    atten_l = 6'd8; #1;
    chk(mute_l == 0, "R7 code 8 passes", mute_l, 0);
    atten_l = 6'h3f;

    // R11 back-pressure
    @(negedge clk);
    out_ready = 0; din_l = 111; din_r = 222; in_valid = 1;
    @(negedge clk);
    din_l = 333; din_r = 444;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R11 stalled ready", in_ready, 0);
    chk(out_valid && sx(dout_l) == 111, "R11 held data", sx(dout_l), 111);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(sx(dout_l) == 333, "R11 next after stall", sx(dout_l), 333);

    // random phase
    win_mag = 4;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 4) != 0;
      din_l = ($urandom % 2) ? DW'(int'($urandom % 17) - 8) : DW'($urandom);
      din_r = ($urandom % 2) ? DW'(int'($urandom % 17) - 8) : DW'($urandom);
      cfg_write = ($urandom % 30) == 0;
      if (cfg_write) begin
        mute_req = $urandom % 2;
        zc_mode  = ($urandom % 4) != 0;
      end
      if ($urandom % 20 == 0) atten_l = 6'($urandom);
      if ($urandom % 20 == 0) atten_r = 6'($urandom);
      if ($urandom % 100 == 0) win_mag = DW'($urandom % 64);
      force_mute_n = ($urandom % 150) != 0;
    end
    @(negedge clk);
    in_valid = 0; cfg_write = 0; force_mute_n = 1;
    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule